// File: doc/BRIEF.md
# Depth-Cascade Hit Arbiter

This block is the per-device arbitration slice that lets a chain of up to 31 search devices act as a single lookup table. Devices sit in blocks of up to eight, and up to four blocks are chained, so the last block holds seven. Lower position numbers have higher priority, both inside a block and between blocks. Each device registers its own local hit for a search and drives that hit to the other devices in its block. It drives a block-level hit to lower-priority blocks. It then looks at the hits arriving from higher-priority devices and blocks and decides whether it owns the result bus for that search.

The device's place in the chain is fixed by parameters: its position inside its block, its block number, and whether it is the last device of the table. Two static configuration inputs choose the span of the table (one device, one block, or several blocks) and the number of extra cycles of hit latency. A device flagged as last takes the result bus with default values when no device in the table hits. Searches may be issued back to back, and each one is arbitrated on its own, in issue order.

Top module: `cascade_hit_arb`

## Requirements
- R1: A search sampled with `srch_vld_i`=1 and `loc_hit_i`=1 drives both bits of `dev_hit_o` high in the following cycle. Otherwise both bits are low in that cycle, and the two bits are always equal.
- R2: Every bit of `blk_hit_o` equals the registered own hit ORed with the upstream peer inputs of R3, whatever the span setting. The lowest-priority device of a block therefore carries the hit of the whole block.
- R3: Bit k of `peer_hit_i` is the hit of block position k when k < DEV_POS, and of position k+1 otherwise. Only bits below DEV_POS are upstream. Bit k of `blk_hit_i` is upstream when k < BLK_POS. Bits that are not upstream have no effect on any output.
- R4: A search whose registered own hit is set, with no upstream peer hit and no upstream block hit in the cycle after issue, produces `win_o`=1.
- R5: A device that hits but sees an upstream hit that the span setting allows keeps `win_o` low for that search.
- R6: When IS_LAST=1, a search with no own hit and no allowed upstream hit produces `dflt_o`=1. `win_o` and `dflt_o` are never high together, and a device with IS_LAST=0 never raises `dflt_o`.
- R7: `span_i` encoding: 2'b00 single device (peer and block inputs ignored); 2'b01 single block (block inputs ignored); 2'b10 and 2'b11 multi-block (both used).
- R8: For a search issued in cycle c, `win_o`, `dflt_o` and `done_o` show its result in cycle c+2+`lat_i`, where `lat_i` ranges 0..3 and is held steady while searches are in flight.
- R9: `done_o` is high for exactly one cycle per issued search. Back-to-back searches give back-to-back results that are each decided independently.
- R10: While `rst_n` is low, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| srch_vld_i | input | 1 | A search is issued this cycle |
| loc_hit_i | input | 1 | This device's own array hit for the issued search |
| peer_hit_i | input | 7 | Hits from the other devices of the block (R3 mapping) |
| blk_hit_i | input | 3 | Hits from other blocks (R3 mapping) |
| span_i | input | 2 | Table span setting (R7) |
| lat_i | input | 2 | Extra result latency in cycles |
| dev_hit_o | output | 2 | Own registered hit, two copies |
| blk_hit_o | output | 3 | Block-level hit to lower-priority blocks, three copies |
| win_o | output | 1 | This device drives the result bus for the search |
| dflt_o | output | 1 | Last device drives default values (global miss) |
| done_o | output | 1 | A search result is due this cycle |

## Verification
The own hit copies are due one cycle after a search is issued. The block-hit copies follow that register and the live peer inputs in the same cycle. The win, default and done results are due 2+`lat_i` cycles after issue. The reference model places each search's expected result in a slot keyed by that due cycle. It compares every output in the middle of every cycle, so an early or late result shows up as a mismatch in two cycles. Latency is changed only after enough idle cycles that no result is in flight.

// File: rtl/cascade_hit_pkg.sv
package cascade_hit_pkg;

  typedef enum logic [1:0] {
    SPAN_DEV       = 2'b00,
    SPAN_BLK       = 2'b01,
    SPAN_MULTI     = 2'b10,
    SPAN_MULTI_ALT = 2'b11
  } span_e;

  typedef struct packed {
    logic vld;
    logic win;
    logic dflt;
  } res_t;

  // Bits strictly below pos are the higher-priority neighbours.
  function automatic logic [31:0] up_mask(input int unsigned pos);
    return (32'd1 << pos) - 32'd1;
  endfunction

  function automatic logic span_uses_peers(input logic [1:0] span);
    return span != SPAN_DEV;
  endfunction

  function automatic logic span_uses_blocks(input logic [1:0] span);
    return span[1];
  endfunction

endpackage

// File: rtl/hit_capture.sv
module hit_capture (
  input  logic clk,
  input  logic rst_n,
  input  logic srch_vld_i,
  input  logic loc_hit_i,
  output logic vld_q,
  output logic hit_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      vld_q <= srch_vld_i;
      hit_q <= srch_vld_i & loc_hit_i;
    end
  end
endmodule

// File: rtl/arb_decide.sv
module arb_decide
  import cascade_hit_pkg::*;
#(
  parameter int unsigned PEER_W  = 7,
  parameter int unsigned BLKIO_W = 3,
  parameter int unsigned DEV_POS = 0,
  parameter int unsigned BLK_POS = 0,
  parameter bit          IS_LAST = 1'b0
) (
  input  logic               vld_q,
  input  logic               hit_q,
  input  logic [PEER_W-1:0]  peer_hit_i,
  input  logic [BLKIO_W-1:0] blk_hit_i,
  input  logic [1:0]         span_i,
  output logic               up_peer_any,
  output logic               up_blk_any,
  output logic               blk_any,
  output logic               dec_win,
  output logic               dec_dflt
);
  localparam logic [PEER_W-1:0]  P_MASK = PEER_W'(up_mask(DEV_POS));
  localparam logic [BLKIO_W-1:0] B_MASK = BLKIO_W'(up_mask(BLK_POS));

  logic raw_peer;
  logic raw_blk;
  logic blocked;

  always_comb begin
    raw_peer    = |(peer_hit_i & P_MASK);
    raw_blk     = |(blk_hit_i & B_MASK);
    up_peer_any = raw_peer & span_uses_peers(span_i);
    up_blk_any  = raw_blk & span_uses_blocks(span_i);
    blocked     = up_peer_any | up_blk_any;
    blk_any     = hit_q | raw_peer;
    dec_win     = vld_q & hit_q & ~blocked;
  end

  generate
    if (IS_LAST) begin : g_last
      assign dec_dflt = vld_q & ~hit_q & ~blocked;
    end else begin : g_mid
      assign dec_dflt = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/result_delay.sv
module result_delay
  import cascade_hit_pkg::*;
#(
  parameter int unsigned MAX_LAT = 3,
  localparam int unsigned LAT_W  = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  res_t             res_i,
  input  logic [LAT_W-1:0] lat_i,
  output res_t             res_o
);
  res_t stg [MAX_LAT+1];
  logic [LAT_W-1:0] sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '0;
    else        stg[0] <= res_i;
  end

  generate
    for (genvar i = 1; i <= MAX_LAT; i++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
      end
    end
  endgenerate

  always_comb begin
    sel   = (lat_i > LAT_W'(MAX_LAT)) ? LAT_W'(MAX_LAT) : lat_i;
    res_o = stg[sel];
  end
endmodule

// File: rtl/cascade_hit_arb.sv
module cascade_hit_arb
  import cascade_hit_pkg::*;
#(
  parameter int unsigned DEVS_PER_BLK = 8,
  parameter int unsigned NUM_BLKS     = 4,
  parameter int unsigned DEV_POS      = 6,
  parameter int unsigned BLK_POS      = 3,
  parameter bit          IS_LAST      = 1'b1,
  parameter int unsigned MAX_LAT      = 3,
  localparam int unsigned PEER_W  = DEVS_PER_BLK - 1,
  localparam int unsigned BLKIO_W = NUM_BLKS - 1,
  localparam int unsigned LAT_W   = (MAX_LAT < 1) ? 1 : $clog2(MAX_LAT + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               srch_vld_i,
  input  logic               loc_hit_i,
  input  logic [PEER_W-1:0]  peer_hit_i,
  input  logic [BLKIO_W-1:0] blk_hit_i,
  input  logic [1:0]         span_i,
  input  logic [LAT_W-1:0]   lat_i,
  output logic [1:0]         dev_hit_o,
  output logic [BLKIO_W-1:0] blk_hit_o,
  output logic               win_o,
  output logic               dflt_o,
  output logic               done_o
);
  // Named internal events, visible to the bound checker.
  logic vld_q;
  logic hit_q;
  logic up_peer_any;
  logic up_blk_any;
  logic blk_any;
  logic dec_win;
  logic dec_dflt;
  res_t dec_res;
  res_t out_res;

  hit_capture u_cap (
    .clk        (clk),
    .rst_n      (rst_n),
    .srch_vld_i (srch_vld_i),
    .loc_hit_i  (loc_hit_i),
    .vld_q      (vld_q),
    .hit_q      (hit_q)
  );

  arb_decide #(
    .PEER_W  (PEER_W),
    .BLKIO_W (BLKIO_W),
    .DEV_POS (DEV_POS),
    .BLK_POS (BLK_POS),
    .IS_LAST (IS_LAST)
  ) u_dec (
    .vld_q       (vld_q),
    .hit_q       (hit_q),
    .peer_hit_i  (peer_hit_i),
    .blk_hit_i   (blk_hit_i),
    .span_i      (span_i),
    .up_peer_any (up_peer_any),
    .up_blk_any  (up_blk_any),
    .blk_any     (blk_any),
    .dec_win     (dec_win),
    .dec_dflt    (dec_dflt)
  );

  always_comb begin
    dec_res.vld  = vld_q;
    dec_res.win  = dec_win;
    dec_res.dflt = dec_dflt;
  end

  result_delay #(
    .MAX_LAT (MAX_LAT)
  ) u_dly (
    .clk   (clk),
    .rst_n (rst_n),
    .res_i (dec_res),
    .lat_i (lat_i),
    .res_o (out_res)
  );

  assign dev_hit_o = {2{hit_q}};
  assign blk_hit_o = {BLKIO_W{blk_any}};
  assign win_o     = out_res.win;
  assign dflt_o    = out_res.dflt;
  assign done_o    = out_res.vld;
endmodule

// File: rtl/cascade_hit_arb_chk.sv
module cascade_hit_arb_chk #(
  parameter int unsigned PEER_W  = 7,
  parameter int unsigned BLKIO_W = 3,
  parameter int unsigned DEV_POS = 6,
  parameter int unsigned LAT_W   = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               srch_vld_i,
  input logic               loc_hit_i,
  input logic [PEER_W-1:0]  peer_hit_i,
  input logic [1:0]         span_i,
  input logic [LAT_W-1:0]   lat_i,
  input logic [1:0]         dev_hit_o,
  input logic [BLKIO_W-1:0] blk_hit_o,
  input logic               win_o,
  input logic               dflt_o,
  input logic               done_o,
  input logic               dec_win
);
  localparam logic [PEER_W-1:0] UPM = PEER_W'((32'd1 << DEV_POS) - 32'd1);

  p_dup_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit_o[0] == dev_hit_o[1]);

  p_hit_follows_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (srch_vld_i && loc_hit_i) |=> dev_hit_o[0]);

  p_no_hit_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !srch_vld_i |=> !dev_hit_o[0]);

  p_blk_copies_r2: assert property (@(posedge clk) disable iff (!rst_n)
    blk_hit_o == {BLKIO_W{blk_hit_o[0]}});

  p_blk_own_r2: assert property (@(posedge clk) disable iff (!rst_n)
    dev_hit_o[0] |-> blk_hit_o[0]);

  p_loser_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_hit_o[0] && (|(peer_hit_i & UPM)) && span_i != 2'b00 && lat_i == '0)
      |=> (!win_o || lat_i != '0));

  p_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(win_o && dflt_o));

  p_lat0_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_win && lat_i == '0) |=> (win_o || lat_i != '0));

  p_win_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (win_o || dflt_o) |-> done_o);
endmodule

bind cascade_hit_arb cascade_hit_arb_chk #(
  .PEER_W  (PEER_W),
  .BLKIO_W (BLKIO_W),
  .DEV_POS (DEV_POS),
  .LAT_W   (LAT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .srch_vld_i (srch_vld_i),
  .loc_hit_i  (loc_hit_i),
  .peer_hit_i (peer_hit_i),
  .span_i     (span_i),
  .lat_i      (lat_i),
  .dev_hit_o  (dev_hit_o),
  .blk_hit_o  (blk_hit_o),
  .win_o      (win_o),
  .dflt_o     (dflt_o),
  .done_o     (done_o),
  .dec_win    (dec_win)
);

// File: tb/cascade_hit_arb_tb.sv
module cascade_hit_arb_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       srch_vld_i = 1'b0;
  logic       loc_hit_i = 1'b0;
  logic [6:0] peer_hit_i = '0;
  logic [2:0] blk_hit_i = '0;
  logic [1:0] span_i = 2'b10;
  logic [1:0] lat_i = 2'd0;
  logic [1:0] dev_hit_o;
  logic [2:0] blk_hit_o;
  logic       win_o, dflt_o, done_o;

  cascade_hit_arb #(
    .DEVS_PER_BLK (8), .NUM_BLKS (4), .DEV_POS (6), .BLK_POS (3),
    .IS_LAST (1'b1), .MAX_LAT (3)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .srch_vld_i (srch_vld_i), .loc_hit_i (loc_hit_i),
    .peer_hit_i (peer_hit_i), .blk_hit_i (blk_hit_i), .span_i (span_i),
    .lat_i (lat_i), .dev_hit_o (dev_hit_o), .blk_hit_o (blk_hit_o),
    .win_o (win_o), .dflt_o (dflt_o), .done_o (done_o)
  );

  always #4 clk = ~clk;  // 125 MHz

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;
  int k = 0;
  bit m_vld = 1'b0, m_hit = 1'b0;
  bit e_win [64];
  bit e_dflt [64];
  bit e_done [64];

  task automatic chk(input string req, input string tag, input logic [2:0] act, input logic [2:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s (%s) cycle %0d actual=%b expected=%b", req, tag, k, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // One clock: drive inputs, model the coming edge, compare after it.
  task automatic step(input bit vld, input bit hit, input logic [6:0] pr,
                      input logic [2:0] bk, input string tag);
    bit up_p, up_b, blocked, own, slot_w, slot_d;
    int slot;
    srch_vld_i = vld; loc_hit_i = hit; peer_hit_i = pr; blk_hit_i = bk;
    up_p = |pr[5:0];               // R3: positions 0..5 outrank position 6
    up_b = |bk;                    // R3: blocks 0..2 outrank block 3
    blocked = (up_p && span_i != 2'b00) || (up_b && span_i[1]);  // R7
    own = vld && hit;
    slot = (k + int'(lat_i)) % 64;
    slot_w = m_vld && m_hit && !blocked;
    slot_d = m_vld && !m_hit && !blocked;
    e_win[slot] = slot_w; e_dflt[slot] = slot_d; e_done[slot] = m_vld;
    m_vld = vld; m_hit = own;
    @(posedge clk);
    @(negedge clk);
    chk("R1", tag, {1'b0, dev_hit_o}, {1'b0, own, own});
    chk("R2", tag, blk_hit_o, {3{own || up_p}});
    chk("R4/R5", tag, {2'b0, win_o}, {2'b0, e_win[k % 64]});
    chk("R6", tag, {2'b0, dflt_o}, {2'b0, e_dflt[k % 64]});
    chk("R8/R9", tag, {2'b0, done_o}, {2'b0, e_done[k % 64]});
    e_win[k % 64] = 1'b0; e_dflt[k % 64] = 1'b0; e_done[k % 64] = 1'b0;
    k++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, '0, '0, "idle");
  endtask

  // A search, then the neighbour hits it sees one cycle later, then a flush.
  task automatic one(input bit hit, input logic [6:0] pr, input logic [2:0] bk, input string tag);
    step(1'b1, hit, '0, '0, tag);
    step(1'b0, 1'b0, pr, bk, tag);
    idle(5);
  endtask

  initial begin
    #(8ns * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int i = 0; i < 64; i++) begin e_win[i] = 0; e_dflt[i] = 0; e_done[i] = 0; end
    repeat (3) @(negedge clk);
    chk("R10", "reset", {win_o, dflt_o, done_o}, 3'b000);
    chk("R10", "reset", {1'b0, dev_hit_o}, 3'b000);
    rst_n = 1'b1;
    idle(2);

    // Multi-block span, zero extra latency.
    span_i = 2'b10; lat_i = 2'd0;
    one(1'b1, 7'h00, 3'b000, "R4 clear win");
    one(1'b1, 7'h04, 3'b000, "R5 peer above");
    one(1'b1, 7'h00, 3'b010, "R5 block above");
    one(1'b0, 7'h00, 3'b000, "R6 global miss");
    one(1'b0, 7'h01, 3'b000, "R6 miss with upstream hit");
    one(1'b1, 7'h40, 3'b000, "R3 downstream peer ignored");
    one(1'b0, 7'h40, 3'b000, "R3 downstream peer no block of default");
    span_i = 2'b11;
    one(1'b1, 7'h00, 3'b100, "R7 alt multi uses blocks");

    // Span modes.
    span_i = 2'b00;
    one(1'b1, 7'h3f, 3'b111, "R7 single device wins");
    one(1'b0, 7'h3f, 3'b111, "R7 single device default");
    span_i = 2'b01;
    one(1'b1, 7'h02, 3'b000, "R7 single block peer");
    one(1'b1, 7'h00, 3'b111, "R7 single block ignores blocks");
    one(1'b0, 7'h00, 3'b001, "R7 single block default");

    // Latency settings; searches back to back.
    span_i = 2'b10;
    for (int l = 0; l < 4; l++) begin
      lat_i = 2'(l);
      step(1'b1, 1'b1, '0, '0, "R8 latency");
      step(1'b1, 1'b0, '0, '0, "R8 latency");
      step(1'b1, 1'b1, '0, '0, "R9 back to back");
      step(1'b0, 1'b0, 7'h08, '0, "R9 back to back");
      idle(6);
    end

    // Mixed traffic at each latency and span.
    for (int l = 0; l < 4; l++) begin
      lat_i = 2'(l);
      for (int s = 0; s < 4; s++) begin
        span_i = 2'(s);
        for (int n = 0; n < 80; n++) begin
          logic [6:0] pr;
          logic [2:0] bk;
          for (int b = 0; b < 7; b++) pr[b] = ($urandom % 8) == 0;
          for (int b = 0; b < 3; b++) bk[b] = ($urandom % 6) == 0;
          step(1'($urandom % 4 != 0), 1'($urandom % 2), pr, bk, "R9 mixed");
        end
        idle(6);
      end
    end
    finish_run();
  end
endmodule